// File: doc/BRIEF.md
# Prefixed Add-Immediate Execution Unit

This unit consumes a stream of 32-bit instruction words and carries out integer add-immediate operations against a private 32 x 64-bit register file. It accepts two encodings. The first is a single word carrying a 16-bit signed immediate. The second is a two-word prefixed pair, in which the prefix word holds the upper 18 bits of a 34-bit immediate and a relative-address flag, and the suffix word holds the lower 16 bits. Any word the unit does not recognise produces a one-cycle illegal pulse and leaves the registers untouched.

Instruction words enter over a valid/ready stream. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. The unit never exerts back-pressure: `in_ready` is high whenever reset is low, and every cycle can take a new word. Holding `in_valid` low inserts a bubble. A bubble between a prefix and its suffix is allowed, because the prefix stays pending until the next accepted word.

Each result leaves on a plain write port (`wr_en`, `wr_idx`, `wr_data`) one cycle after its last word is accepted. The register file is updated on that same edge, so the very next word already reads the new value.

Top module: `addi_exec_unit`

## Requirements
- R1: Bit k of the specification maps to `in_word[31-k]`. A word accepted with no prefix pending and major opcode `in_word[31:26]` = 14 is an add. One cycle later it drives `wr_en`=1 and `wr_idx` = `in_word[25:21]`, and `wr_data` = base + immediate.
- R2: The source field is `in_word[20:16]`. When it is 0 the base is the constant zero, even if register 0 holds a non-zero value; otherwise the base is the named register.
- R3: For the single-word form, the immediate `in_word[15:0]` is sign-extended to 64 bits.
- R4: A word with no prefix pending is a prefix when `in_word[31:26]`=1, `in_word[25:24]`=2'b10 and `in_word[23]`=0. Bits 22:21 and 19:18 are ignored. A prefix causes neither a write nor an illegal pulse, and it stays pending across any number of idle cycles until the next accepted word.
- R5: A word accepted while a prefix is pending is the suffix. If its opcode is 14, the immediate is `{prefix[17:0], suffix[15:0]}`, a 34-bit value sign-extended to 64 bits. With the relative flag `prefix[20]`=0, the base follows R2 using the suffix source field. The destination is the suffix's `in_word[25:21]`.
- R6: With `prefix[20]`=1, the base is the `in_addr` value sampled with the prefix word. The suffix's `in_addr` and its source field are ignored.
- R7: A suffix whose opcode is not 14, including another prefix, gives `illegal`=1 for exactly one cycle with no write and no register change. It also clears the pending state, so the next word is decoded fresh.
- R8: With no prefix pending, any word that is neither an add nor a valid prefix gives one cycle of `illegal`=1 with no write and no register change. This covers opcode 9 and opcode 1 with bits 25:23 other than 3'b100.
- R9: A word accepted in the cycle right after an add reads that add's result when its source is the add's destination.
- R10: Reset clears the pending prefix, `wr_en` and `illegal`, and sets every register to zero.
- R11: `in_ready` is 1 whenever reset is low. `wr_en` and `illegal` rise only in the cycle after an accepted word, and a cycle with `in_valid`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Unit takes a word this cycle |
| in_word | input | 32 | Instruction word |
| in_addr | input | 64 | Address of the current instruction |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Destination register |
| wr_data | output | 64 | Value written |
| illegal | output | 1 | Unrecognised word, one-cycle pulse |

## Verification
The cases of interest are those where two functions share an edge. One is a register-file write retiring from one add while the next word, accepted in the following cycle, reads that same register (R9). The other is a suffix decode taking place in the cycle a stale prefix would otherwise still steer it (R7).

The bench provokes the first with back-to-back dependent adds and with random streams that have no idle gaps. It provokes the second with prefix-prefix and prefix-bad-suffix pairs that are followed at once by a plain add. A scoreboard model holds its own register copy and pending-prefix state and judges every write and illegal pulse in order.

// File: rtl/addi_exec_pkg.sv
package addi_exec_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 6;
  localparam int FLD_W  = 5;
  localparam int SI_W   = 16;
  localparam int HI_W   = 18;
  localparam int PI_W   = SI_W + HI_W;
  localparam logic [OP_W-1:0] OP_ADD = 6'd14;
  localparam logic [OP_W-1:0] OP_PFX = 6'd1;
  localparam logic [1:0]      PFX_CLASS = 2'b10;

  typedef enum logic [1:0] {
    K_NONE    = 2'd0,
    K_ADD     = 2'd1,
    K_PREFIX  = 2'd2,
    K_ILLEGAL = 2'd3
  } kind_e;
endpackage

// File: rtl/addi_exec_decode.sv
module addi_exec_decode
  import addi_exec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [WORD_W-1:0] word,
  input  logic              pend,
  input  logic [HI_W-1:0]   pend_hi,
  input  logic              pend_rel,
  output kind_e             kind,
  output logic [FLD_W-1:0]  rt,
  output logic [FLD_W-1:0]  ra,
  output logic              base_zero,
  output logic              base_addr,
  output logic [XLEN-1:0]   imm,
  output logic [HI_W-1:0]   hi_field,
  output logic              rel_flag
);
  localparam int SHORT_PAD = XLEN - SI_W;
  localparam int LONG_PAD  = XLEN - PI_W;

  logic [OP_W-1:0] op;
  logic [SI_W-1:0] si;
  logic [PI_W-1:0] joined;
  logic            is_pfx;

  assign op       = word[31:26];
  assign rt       = word[25:21];
  assign ra       = word[20:16];
  assign si       = word[15:0];
  assign hi_field = word[17:0];
  assign rel_flag = word[20];
  assign joined   = {pend_hi, si};
  assign is_pfx   = (op == OP_PFX) && (word[25:24] == PFX_CLASS) && !word[23];

  always_comb begin
    kind      = K_ILLEGAL;
    base_addr = 1'b0;
    base_zero = (ra == '0);
    imm       = {{SHORT_PAD{si[SI_W-1]}}, si};
    if (pend) begin
      if (op == OP_ADD) begin
        kind      = K_ADD;
        imm       = {{LONG_PAD{joined[PI_W-1]}}, joined};
        base_addr = pend_rel;
      end
    end else if (op == OP_ADD) begin
      kind = K_ADD;
    end else if (is_pfx) begin
      kind = K_PREFIX;
    end
  end
endmodule

// File: rtl/addi_exec_regfile.sv
module addi_exec_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   rd_idx,
  output logic [XLEN-1:0] rd_data,
  input  logic            we,
  input  logic [AW-1:0]   we_idx,
  input  logic [XLEN-1:0] we_data
);
  logic [XLEN-1:0] regs [NREG];

  assign rd_data = regs[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[we_idx] <= we_data;
    end
  end
endmodule

// File: rtl/addi_exec_unit.sv
module addi_exec_unit
  import addi_exec_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [XLEN-1:0]   in_addr,
  output logic              wr_en,
  output logic [FLD_W-1:0]  wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic              illegal
);
  logic            take;
  logic            pend_q;
  logic [HI_W-1:0] pend_hi_q;
  logic            pend_rel_q;
  logic [XLEN-1:0] pend_addr_q;

  kind_e            kind;
  logic [FLD_W-1:0] rt, ra;
  logic             base_zero, base_addr, rel_flag;
  logic [XLEN-1:0]  imm, rd_data, base, sum;
  logic [HI_W-1:0]  hi_field;

  assign in_ready = !rst;
  assign take     = in_valid && in_ready;

  addi_exec_decode #(.XLEN(XLEN)) u_dec (
    .word      (in_word),
    .pend      (pend_q),
    .pend_hi   (pend_hi_q),
    .pend_rel  (pend_rel_q),
    .kind      (kind),
    .rt        (rt),
    .ra        (ra),
    .base_zero (base_zero),
    .base_addr (base_addr),
    .imm       (imm),
    .hi_field  (hi_field),
    .rel_flag  (rel_flag)
  );

  addi_exec_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (ra),
    .rd_data (rd_data),
    .we      (take && (kind == K_ADD)),
    .we_idx  (rt),
    .we_data (sum)
  );

  always_comb begin
    if (base_addr)      base = pend_addr_q;
    else if (base_zero) base = '0;
    else                base = rd_data;
    sum = base + imm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_hi_q   <= '0;
      pend_rel_q  <= 1'b0;
      pend_addr_q <= '0;
      wr_en       <= 1'b0;
      wr_idx      <= '0;
      wr_data     <= '0;
      illegal     <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      illegal <= 1'b0;
      if (take) begin
        unique case (kind)
          K_PREFIX: begin
            pend_q      <= 1'b1;
            pend_hi_q   <= hi_field;
            pend_rel_q  <= rel_flag;
            pend_addr_q <= in_addr;
          end
          K_ADD: begin
            pend_q  <= 1'b0;
            wr_en   <= 1'b1;
            wr_idx  <= rt;
            wr_data <= sum;
          end
          default: begin
            pend_q  <= 1'b0;
            illegal <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/addi_exec_checker.sv
module addi_exec_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [31:0]     in_word,
  input logic            wr_en,
  input logic [4:0]      wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic            illegal,
  input logic            pend_q
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && illegal));

  p_ready_r11: assert property (@(posedge clk) disable iff (rst) in_ready);

  p_cause_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en || illegal) |-> $past(acc));

  p_prefix_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && !pend_q && in_word[31:26] == 6'd1 && in_word[25:23] == 3'b100)
    |=> (!wr_en && !illegal && pend_q));

  p_plain_dest_r1: assert property (@(posedge clk) disable iff (rst)
    (acc && !pend_q && in_word[31:26] == 6'd14)
    |=> (wr_en && wr_idx == $past(in_word[25:21])));

  p_zero_base_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && !pend_q && in_word[31:26] == 6'd14 && in_word[20:16] == 5'd0)
    |=> (wr_data == {{(XLEN-16){$past(in_word[15])}}, $past(in_word[15:0])}));

  p_bad_suffix_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && pend_q && in_word[31:26] != 6'd14)
    |=> (illegal && !wr_en && !pend_q));

  p_vector_word_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && !pend_q && in_word[31:26] == 6'd9) |=> (illegal && !wr_en));
endmodule

bind addi_exec_unit addi_exec_checker #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_word  (in_word),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data),
  .illegal  (illegal),
  .pend_q   (pend_q)
);

// File: tb/addi_exec_unit_test.sv
`timescale 1ns/1ps
module addi_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [63:0] in_addr = '0;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  logic        illegal;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  addi_exec_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_addr(in_addr), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .illegal(illegal)
  );

  typedef struct packed {
    logic        ill;
    logic [4:0]  idx;
    logic [63:0] data;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [63:0] mreg [32];
  logic        m_pend = 1'b0;
  logic [17:0] m_hi   = '0;
  logic        m_rel  = 1'b0;
  logic [63:0] m_addr = '0;

  function automatic logic [31:0] add_w(input int rt, input int ra, input logic [15:0] si);
    return {6'd14, rt[4:0], ra[4:0], si};
  endfunction

  function automatic logic [31:0] pfx_w(input logic r, input logic [17:0] hi, input logic [3:0] rsv);
    return {6'd1, 2'b10, 1'b0, rsv[3:2], r, rsv[1:0], hi};
  endfunction

  task automatic push(input logic ill, input logic [4:0] idx, input logic [63:0] d, input string tag);
    exp_t e;
    e.ill = ill; e.idx = idx; e.data = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [31:0] w, input logic [63:0] a, input string tag);
    logic [63:0] base, imm, res;
    logic [33:0] j;
    in_valid = 1'b1; in_word = w; in_addr = a;
    if (m_pend) begin
      m_pend = 1'b0;
      if (w[31:26] == 6'd14) begin
        j    = {m_hi, w[15:0]};
        imm  = {{30{j[33]}}, j};
        base = m_rel ? m_addr : (w[20:16] == 5'd0 ? 64'd0 : mreg[w[20:16]]);
        res  = base + imm;
        push(1'b0, w[25:21], res, tag);
        mreg[w[25:21]] = res;
      end else begin
        push(1'b1, '0, '0, tag);
      end
    end else if (w[31:26] == 6'd14) begin
      imm  = {{48{w[15]}}, w[15:0]};
      base = (w[20:16] == 5'd0) ? 64'd0 : mreg[w[20:16]];
      res  = base + imm;
      push(1'b0, w[25:21], res, tag);
      mreg[w[25:21]] = res;
    end else if (w[31:26] == 6'd1 && w[25:23] == 3'b100) begin
      m_pend = 1'b1; m_hi = w[17:0]; m_rel = w[20]; m_addr = a;
    end else begin
      push(1'b1, '0, '0, tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n, input logic [31:0] junk);
    in_valid = 1'b0; in_word = junk;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && (wr_en || illegal)) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R11 unexpected output: en=%0b ill=%0b idx=%0d data=%h, expected none",
                 wr_en, illegal, wr_idx, wr_data);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e.ill) begin
          if (!illegal || wr_en) begin
            bad++;
            $display("FAIL %s: en=%0b ill=%0b, expected en=0 ill=1", t, wr_en, illegal);
          end
        end else if (!wr_en || illegal || wr_idx !== e.idx || wr_data !== e.data) begin
          bad++;
          $display("FAIL %s: en=%0b ill=%0b idx=%0d data=%h, expected en=1 ill=0 idx=%0d data=%h",
                   t, wr_en, illegal, wr_idx, wr_data, e.idx, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state at the ports
    total++;
    if (wr_en !== 1'b0 || illegal !== 1'b0) begin
      bad++;
      $display("FAIL R10: en=%0b ill=%0b, expected 0 0", wr_en, illegal);
    end
    // R11: ready out of reset
    total++;
    if (in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R11: in_ready=%0b, expected 1", in_ready);
    end

    send(add_w(5, 7, 16'd0), 64'h0, "R10");       // register starts at zero
    send(add_w(1, 0, 16'd100), 64'h0, "R2");
    send(add_w(2, 0, 16'hFFFB), 64'h0, "R3");     // -5 sign-extended
    send(add_w(4, 1, 16'd7), 64'h0, "R1");
    send(add_w(4, 4, 16'd7), 64'h0, "R9");        // back-to-back dependence
    send(add_w(0, 0, 16'd50), 64'h0, "R1");
    send(add_w(6, 0, 16'd1), 64'h0, "R2");        // RA=0 ignores r0 = 50
    send(add_w(3, 2, 16'h8000), 64'h0, "R3");
    idle(2, 32'hFFFF_FFFF);                       // R11: junk without valid

    send(pfx_w(1'b0, 18'h3FFFF, 4'h0), 64'h100, "R4");
    send(add_w(8, 1, 16'h8000), 64'h200, "R5");   // negative 34-bit imm
    send(pfx_w(1'b0, 18'h00001, 4'h0), 64'h0, "R4");
    idle(3, 32'h3800_0000);
    send(add_w(9, 4, 16'h0003), 64'h0, "R4");
    send(pfx_w(1'b0, 18'h1FFFF, 4'hF), 64'h0, "R4"); // reserved bits set
    send(add_w(10, 0, 16'hFFFF), 64'h0, "R5");
    send(pfx_w(1'b1, 18'h00002, 4'h0), 64'h1234_5678_0000_1000, "R6");
    send(add_w(11, 1, 16'h0010), 64'hDEAD_0000_0000_0000, "R6");
    send(pfx_w(1'b1, 18'h3FFFF, 4'h0), 64'h40, "R6");
    send(add_w(12, 0, 16'hFFF0), 64'h80, "R6");

    send(pfx_w(1'b0, 18'h00005, 4'h0), 64'h0, "R7");
    send({6'd12, 5'd1, 5'd0, 16'd9}, 64'h0, "R7");  // bad suffix
    send(add_w(13, 0, 16'd2), 64'h0, "R7");         // pending cleared
    send(pfx_w(1'b0, 18'h00005, 4'h0), 64'h0, "R7");
    send(pfx_w(1'b0, 18'h00006, 4'h0), 64'h0, "R7");
    send(add_w(14, 0, 16'd3), 64'h0, "R7");

    send({6'd9, 5'd1, 5'd1, 16'd1}, 64'h0, "R8");
    send({6'd1, 2'b01, 1'b0, 5'd1, 16'd1}, 64'h0, "R8");
    send({6'd1, 2'b10, 1'b1, 5'd1, 16'd1}, 64'h0, "R8");
    send(add_w(15, 1, 16'd0), 64'h0, "R8");         // r1 untouched

    for (int i = 0; i < 200; i++) begin
      int sel;
      sel = $urandom % 5;
      if (sel < 2) begin
        send(add_w($urandom % 32, $urandom % 32, 16'($urandom)), 64'h0, "R1");
      end else if (sel < 4) begin
        send(pfx_w(1'($urandom), 18'($urandom), 4'($urandom)), {32'($urandom), 32'($urandom)}, "R5");
        if ($urandom % 3 == 0) idle(1 + $urandom % 3, 32'($urandom));
        send(add_w($urandom % 32, $urandom % 32, 16'($urandom)), {32'($urandom), 32'($urandom)}, "R5");
      end else begin
        send({6'($urandom % 13 + 15), 26'($urandom)}, 64'h0, "R8");
      end
    end

    idle(4, 32'h0);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R11: %0d results missing, expected 0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule